// File: doc/BRIEF.md
# DMA Bus Request Gate with Interrupt Hold-Off

This block stands between the per-channel DMA logic and the bus controller. Each channel signals an accepted transfer request with a one-cycle pulse. The block records that request as a pending bit. It raises a single bus request and waits for the bus controller's grant. It then lets the transfer run block by block. While bus ownership is held, the channel logic pulses a block-end strobe after each transfer unit. With that strobe it marks whether the unit just finished was the last one of that channel's transfer.

Two conditions hold DMA off. The first is an urgent interrupt: either a non-maskable request, or a maskable request whose level, taken as an unsigned number, is strictly above a programmable hold level. The second is a nestable software suppress count, which interrupt handlers raise on entry and lower on exit. Neither condition cuts a block short. The block waits for the next block end, releases the bus there and keeps every pending request. It asks for the bus again once the condition is gone.

Top module: `dma_bus_holdoff`

## Requirements
- R1: After reset, `bus_req_o`, `xfer_en_o`, `pend_o` and `sup_cnt_o` are all zero.
- R2: A `req_set_i` pulse with no hold-off active raises `bus_req_o` at the next clock edge. `xfer_en_o` rises only at the edge after a cycle in which `bus_gnt_i` was high while the request was outstanding.
- R3: Hold-off is active when `nmi_i` is high regardless of levels, or when `irq_pend_i` is high and `irq_lvl_i` > `hold_lvl_i` (unsigned). During a transfer, hold-off is honoured only at a `blk_end_i` pulse: `bus_req_o` and `xfer_en_o` stay high until that pulse and fall at the edge that samples it.
- R4: A channel's pending bit in `pend_o` (bit i = channel i) is cleared only by a `blk_end_i` pulse with `xfer_last_i` high while that channel is active. Hold-off never clears it.
- R5: When the hold-off condition clears with requests still pending, `bus_req_o` rises again at the next clock edge.
- R6: A maskable interrupt with `irq_lvl_i` <= `hold_lvl_i` does not end the transfer: `bus_req_o` stays high across `blk_end_i`.
- R7: While `sup_cnt_o` is nonzero and the bus is not requested, no pending request raises `bus_req_o`.
- R8: `sup_inc_i` adds one and `sup_dec_i` subtracts one from the 4-bit `sup_cnt_o`. Both together leave it unchanged. It saturates at 15 and at 0.
- R9: When `sup_cnt_o` returns to zero with requests pending and no interrupt hold-off, `bus_req_o` rises at the following edge.
- R10: A suppress count that becomes nonzero in the middle of a block takes effect only at the next `blk_end_i`.
- R11: While a transfer runs and another channel is pending, `bus_req_o` stays high without a gap across block ends. When the active channel finishes, the lowest-numbered pending channel becomes `act_ch_o`.
- R12: If hold-off appears while the bus is requested but not yet granted, `bus_req_o` falls at the next edge. Hold-off wins over a grant in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_set_i | input | NCH | Per-channel accepted-request pulse |
| blk_end_i | input | 1 | Pulse at the end of a transfer unit |
| xfer_last_i | input | 1 | With blk_end_i: the unit ended the active channel's transfer |
| bus_gnt_i | input | 1 | Bus ownership grant from the bus controller |
| nmi_i | input | 1 | Non-maskable interrupt pending |
| irq_pend_i | input | 1 | Maskable interrupt pending |
| irq_lvl_i | input | LVL_W | Level of the pending maskable interrupt |
| hold_lvl_i | input | LVL_W | Hold-off threshold level |
| sup_inc_i | input | 1 | Increment software suppress count |
| sup_dec_i | input | 1 | Decrement software suppress count |
| bus_req_o | output | 1 | Bus request to the bus controller |
| xfer_en_o | output | 1 | Transfer may proceed on the active channel |
| act_ch_o | output | CH_W | Index of the active channel |
| pend_o | output | NCH | Pending request bits |
| sup_cnt_o | output | SUP_W | Software suppress count |

## Verification
Directed sequences cover the edge cases. An NMI is raised in the middle of a block with the hold level at its maximum, to show that it overrides the level test. Maskable levels are set equal to and one above the hold level, which separates the strict comparison from a non-strict one. Hold-off is raised before a grant arrives and in the same cycle as one, which shows that hold-off wins. The suppress count is driven through nesting, both saturation limits and simultaneous increment and decrement, while requests wait. Several channels are queued, which checks that the bus request has no gap between blocks and that the lowest channel is picked next. A long seeded random run mixes all of these against a cycle model in the bench.

// File: rtl/dma_hold_pkg.sv
package dma_hold_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } bus_st_e;
endpackage

// File: rtl/dma_hold_cond.sv
module dma_hold_cond #(
    parameter int LVL_W = 5
) (
    input  logic             nmi_i,
    input  logic             irq_pend_i,
    input  logic [LVL_W-1:0] irq_lvl_i,
    input  logic [LVL_W-1:0] hold_lvl_i,
    input  logic             sup_busy_i,
    output logic             irq_hold_o,
    output logic             hold_o
);
    always_comb begin
        irq_hold_o = nmi_i || (irq_pend_i && (irq_lvl_i > hold_lvl_i));
        hold_o     = irq_hold_o || sup_busy_i;
    end
endmodule

// File: rtl/dma_sup_cnt.sv
module dma_sup_cnt #(
    parameter int SUP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [SUP_W-1:0] cnt_o,
    output logic             busy_o
);
    localparam logic [SUP_W-1:0] CNT_MAX = {SUP_W{1'b1}};

    typedef struct packed {
        logic [SUP_W-1:0] cnt;
    } sup_s;

    sup_s sup_d, sup_q;

    always_comb begin
        sup_d = sup_q;
        if (inc_i && !dec_i && sup_q.cnt != CNT_MAX) begin
            sup_d.cnt = sup_q.cnt + 1'b1;
        end else if (dec_i && !inc_i && sup_q.cnt != '0) begin
            sup_d.cnt = sup_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sup_q <= '0;
        else        sup_q <= sup_d;
    end

    assign cnt_o  = sup_q.cnt;
    assign busy_o = (sup_q.cnt != '0);

    // R8
    sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_q.cnt == CNT_MAX && inc_i && !dec_i) |=> (sup_q.cnt == CNT_MAX));
    // R8
    sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_q.cnt == '0 && dec_i && !inc_i) |=> (sup_q.cnt == '0));
    // R8
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && dec_i) |=> $stable(sup_q.cnt));
endmodule

// File: rtl/dma_pend_trk.sv
module dma_pend_trk #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  set_i,
    input  logic            clr_i,
    input  logic [CH_W-1:0] clr_ch_i,
    output logic [NCH-1:0]  pend_o,
    output logic            any_nxt_o,
    output logic [CH_W-1:0] first_nxt_o
);
    typedef struct packed {
        logic [NCH-1:0] pend;
    } pend_s;

    pend_s          pend_d, pend_q;
    logic [NCH-1:0] clr_mask;

    always_comb begin
        clr_mask = '0;
        if (clr_i) clr_mask[clr_ch_i] = 1'b1;
        pend_d.pend = (pend_q.pend & ~clr_mask) | set_i;
        any_nxt_o   = |pend_d.pend;
        first_nxt_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend_d.pend[i]) first_nxt_o = CH_W'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q.pend;

    // R4
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((pend_q.pend & $past(pend_q.pend)) == $past(pend_q.pend)));
endmodule

// File: rtl/dma_bus_holdoff.sv
module dma_bus_holdoff
    import dma_hold_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int LVL_W = 5,
    parameter int SUP_W = 4,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   req_set_i,
    input  logic             blk_end_i,
    input  logic             xfer_last_i,
    input  logic             bus_gnt_i,
    input  logic             nmi_i,
    input  logic             irq_pend_i,
    input  logic [LVL_W-1:0] irq_lvl_i,
    input  logic [LVL_W-1:0] hold_lvl_i,
    input  logic             sup_inc_i,
    input  logic             sup_dec_i,
    output logic             bus_req_o,
    output logic             xfer_en_o,
    output logic [CH_W-1:0]  act_ch_o,
    output logic [NCH-1:0]   pend_o,
    output logic [SUP_W-1:0] sup_cnt_o
);
    typedef struct packed {
        bus_st_e         st;
        logic [CH_W-1:0] act;
    } fsm_s;

    fsm_s            fsm_d, fsm_q;
    logic            sup_busy, irq_hold, hold;
    logic            clr_act, any_nxt;
    logic [CH_W-1:0] first_nxt;

    dma_sup_cnt #(.SUP_W(SUP_W)) u_sup (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (sup_inc_i),
        .dec_i  (sup_dec_i),
        .cnt_o  (sup_cnt_o),
        .busy_o (sup_busy)
    );

    dma_hold_cond #(.LVL_W(LVL_W)) u_cond (
        .nmi_i      (nmi_i),
        .irq_pend_i (irq_pend_i),
        .irq_lvl_i  (irq_lvl_i),
        .hold_lvl_i (hold_lvl_i),
        .sup_busy_i (sup_busy),
        .irq_hold_o (irq_hold),
        .hold_o     (hold)
    );

    assign clr_act = (fsm_q.st == ST_XFER) && blk_end_i && xfer_last_i;

    dma_pend_trk #(.NCH(NCH), .CH_W(CH_W)) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (req_set_i),
        .clr_i       (clr_act),
        .clr_ch_i    (fsm_q.act),
        .pend_o      (pend_o),
        .any_nxt_o   (any_nxt),
        .first_nxt_o (first_nxt)
    );

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_IDLE: begin
                if (any_nxt && !hold) fsm_d.st = ST_REQ;
            end
            ST_REQ: begin
                if (hold || !any_nxt) begin
                    fsm_d.st = ST_IDLE;
                end else if (bus_gnt_i) begin
                    fsm_d.st  = ST_XFER;
                    fsm_d.act = first_nxt;
                end
            end
            ST_XFER: begin
                if (blk_end_i) begin
                    if (hold || !any_nxt) begin
                        fsm_d.st = ST_IDLE;
                    end else if (xfer_last_i) begin
                        fsm_d.act = first_nxt;
                    end
                end
            end
            default: fsm_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: ST_IDLE, act: '0};
        else        fsm_q <= fsm_d;
    end

    assign bus_req_o = (fsm_q.st != ST_IDLE);
    assign xfer_en_o = (fsm_q.st == ST_XFER);
    assign act_ch_o  = fsm_q.act;

    // R3
    midblk_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_XFER && !blk_end_i) |=> (fsm_q.st == ST_XFER));
    // R2
    gnt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_REQ && !bus_gnt_i) |=> (fsm_q.st != ST_XFER));
    // R7
    sup_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_IDLE && sup_cnt_o != '0) |=> (fsm_q.st == ST_IDLE));
    // R11
    act_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_XFER) |-> pend_o[fsm_q.act]);
    // R12
    pre_gnt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_REQ && irq_hold) |=> (fsm_q.st == ST_IDLE));
endmodule

// File: tb/tb_dma_bus_holdoff.sv
`timescale 1ns/1ps
module tb_dma_bus_holdoff;
    localparam int NCH = 4, LVL_W = 5, SUP_W = 4, CH_W = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NCH-1:0] req_set = '0;
    logic blk_end = 0, xfer_last = 0, gnt = 0, nmi = 0, irqp = 0, inc = 0, dec = 0;
    logic [LVL_W-1:0] lvl = '0, hlvl = '0;
    logic bus_req, xfer_en;
    logic [CH_W-1:0] act;
    logic [NCH-1:0] pend;
    logic [SUP_W-1:0] sup;

    int n_chk = 0, n_fail = 0;
    int r_st = 0;
    logic [NCH-1:0] r_pend = '0;
    logic [SUP_W-1:0] r_sup = '0;
    logic [CH_W-1:0] r_act = '0;

    always #4 clk = ~clk;

    dma_bus_holdoff dut (
        .clk(clk), .rst_n(rst_n), .req_set_i(req_set), .blk_end_i(blk_end),
        .xfer_last_i(xfer_last), .bus_gnt_i(gnt), .nmi_i(nmi), .irq_pend_i(irqp),
        .irq_lvl_i(lvl), .hold_lvl_i(hlvl), .sup_inc_i(inc), .sup_dec_i(dec),
        .bus_req_o(bus_req), .xfer_en_o(xfer_en), .act_ch_o(act),
        .pend_o(pend), .sup_cnt_o(sup)
    );

    task automatic chk(input logic ok, input string req, input int actual, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expv, $time);
        end
    endtask

    function automatic logic [CH_W-1:0] lowest(input logic [NCH-1:0] m);
        logic [CH_W-1:0] r = '0;
        for (int i = NCH - 1; i >= 0; i--) if (m[i]) r = CH_W'(i);
        return r;
    endfunction

    function automatic logic held();
        return nmi || (irqp && lvl > hlvl) || (r_sup != 0);
    endfunction

    task automatic model_update();
        logic [NCH-1:0] pn;
        logic h;
        h  = held();
        pn = r_pend;
        if (r_st == 2 && blk_end && xfer_last) pn[r_act] = 1'b0;
        pn = pn | req_set;
        if (inc && !dec && r_sup != 4'hF) r_sup = r_sup + 1'b1;
        else if (dec && !inc && r_sup != 0) r_sup = r_sup - 1'b1;
        case (r_st)
            0: if (pn != 0 && !h) r_st = 1;
            1: if (h || pn == 0) r_st = 0;
               else if (gnt) begin r_st = 2; r_act = lowest(pn); end
            default: if (blk_end) begin
                if (h || pn == 0) r_st = 0;
                else if (xfer_last) r_act = lowest(pn);
            end
        endcase
        r_pend = pn;
    endtask

    task automatic cmp_model();
        chk(bus_req == (r_st != 0), "R5 model bus_req", int'(bus_req), int'(r_st != 0));
        chk(xfer_en == (r_st == 2), "R2 model xfer_en", int'(xfer_en), int'(r_st == 2));
        chk(pend == r_pend, "R4 model pend", int'(pend), int'(r_pend));
        chk(sup == r_sup, "R8 model sup", int'(sup), int'(r_sup));
        if (r_st == 2) chk(act == r_act, "R11 model act", int'(act), int'(r_act));
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        cmp_model();
        req_set = '0; blk_end = 0; xfer_last = 0; inc = 0; dec = 0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!bus_req && !xfer_en, "R1 outputs idle", int'(bus_req), 0);
        chk(pend == 0 && sup == 0, "R1 pend/sup zero", int'(pend), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 request then grant
        req_set = 4'b0100; step();
        chk(bus_req == 1, "R2 bus_req after pulse", int'(bus_req), 1);
        step(); step();
        chk(xfer_en == 0, "R2 no xfer before grant", int'(xfer_en), 0);
        gnt = 1; step();
        chk(xfer_en == 1 && act == 2, "R2 xfer after grant", int'(act), 2);

        // R3 NMI mid-block with maximum hold level
        nmi = 1; hlvl = 5'h1F; step(); step();
        chk(bus_req == 1, "R3 held until block end", int'(bus_req), 1);
        blk_end = 1; step();
        chk(bus_req == 0, "R3 drop at block end", int'(bus_req), 0);
        gnt = 0; step(); step();
        chk(pend == 4'b0100, "R4 pending retained", int'(pend), 4);
        nmi = 0; step();
        chk(bus_req == 1, "R5 re-request", int'(bus_req), 1);
        gnt = 1; step();

        // R6 level equal to threshold: no preemption
        irqp = 1; lvl = 5'd3; hlvl = 5'd3; blk_end = 1; step();
        chk(bus_req == 1 && xfer_en == 1, "R6 equal level ignored", int'(bus_req), 1);
        lvl = 5'd4; blk_end = 1; step();
        chk(bus_req == 0, "R3 higher level drops", int'(bus_req), 0);
        irqp = 0; gnt = 0; step();
        gnt = 1; step();

        // R11 queued channels, continuous request
        req_set = 4'b0011; step();
        blk_end = 1; xfer_last = 1; step();
        chk(bus_req == 1 && act == 0, "R11 switch to ch0", int'(act), 0);
        chk(pend == 4'b0011, "R4 finished ch2 cleared", int'(pend), 3);
        blk_end = 1; xfer_last = 1; step();
        chk(bus_req == 1 && act == 1, "R11 switch to ch1", int'(act), 1);
        blk_end = 1; xfer_last = 1; step();
        chk(bus_req == 0 && pend == 0, "R11 all done", int'(pend), 0);
        gnt = 0;

        // R8 saturation and nesting
        for (int i = 0; i < 17; i++) begin inc = 1; step(); end
        chk(sup == 15, "R8 saturate high", int'(sup), 15);
        inc = 1; dec = 1; step();
        chk(sup == 15, "R8 inc+dec hold", int'(sup), 15);
        for (int i = 0; i < 16; i++) begin dec = 1; step(); end
        chk(sup == 0, "R8 saturate low", int'(sup), 0);
        inc = 1; step(); inc = 1; step();
        req_set = 4'b1000; step(); step();
        chk(bus_req == 0 && pend == 4'b1000, "R7 suppressed", int'(bus_req), 0);
        dec = 1; step();
        chk(bus_req == 0 && sup == 1, "R7 nested still suppressed", int'(sup), 1);
        dec = 1; step();
        chk(sup == 0 && bus_req == 0, "R9 count zero", int'(sup), 0);
        step();
        chk(bus_req == 1, "R9 request after zero", int'(bus_req), 1);

        // R10 suppress raised mid-block
        gnt = 1; step();
        inc = 1; step(); step();
        chk(bus_req == 1 && xfer_en == 1, "R10 mid-block continues", int'(bus_req), 1);
        blk_end = 1; step();
        chk(bus_req == 0, "R10 drop at boundary", int'(bus_req), 0);
        gnt = 0; dec = 1; step(); step();

        // R12 hold-off before grant, hold beats same-cycle grant
        chk(bus_req == 1, "R12 requesting", int'(bus_req), 1);
        nmi = 1; gnt = 1; step();
        chk(bus_req == 0 && xfer_en == 0, "R12 withdrawn", int'(bus_req), 0);
        nmi = 0; gnt = 0; step(); gnt = 1; step();
        blk_end = 1; xfer_last = 1; step();
        gnt = 0; step();

        // random phase
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 6 == 0) req_set = NCH'($urandom);
            if ($urandom % 20 == 0) nmi = ~nmi & ($urandom % 3 == 0);
            if ($urandom % 10 == 0) begin
                irqp = $urandom % 2; lvl = LVL_W'($urandom % 8); hlvl = LVL_W'($urandom % 8);
            end
            gnt = (r_st != 0) && ($urandom % 3 != 0);
            if (r_st == 2 && $urandom % 3 == 0) begin
                blk_end = 1; xfer_last = $urandom % 2;
            end
            if ($urandom % 15 == 0 && r_sup < 3) inc = 1;
            else if ($urandom % 12 == 0) dec = 1;
            step();
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule